// File: doc/BRIEF.md
# Mode-Selectable 16-bit Timer/Event Counter

This block is a 16-bit up-counter advanced by a one-cycle count-enable strobe. It has two 16-bit capture/compare registers, a small control register, a sticky overflow flag, a toggle output and a registered interrupt pulse. A two-bit mode field picks one of four behaviours. In stop mode the counter is held at zero. In free-running mode it wraps from FFFFH to 0000H. In edge-clear mode it restarts on a rising edge of event input 0. In match-clear mode it restarts when it equals capture/compare register 0.

Each capture/compare register has its own mode bit. As a compare register, a match with the counter raises the interrupt and flips the toggle output. As a capture register, a rising edge on its event input loads the counter value, and the interrupt follows at the next count-enable. Both event inputs are asynchronous levels, and each passes through a synchronizer before its rising edge is detected. Software reaches the registers through a flat word-addressed register bus. Address 0 is control, address 1 is register 0, address 2 is register 1, and address 3 reads the counter.

Top module: `evtTimer16`

## Requirements
- R1: After reset the control register reads 00H, the counter reads 0, and toggleOut and irqOut are low.
- R2: With mode bits [3:2] = 00 (stop), the counter is held at 0. Events on both inputs cause no capture, no interrupt and no toggle.
- R3: With mode 01 (free-running), the counter rises by one on each clock cycle in which cntEn is high. It holds when cntEn is low and wraps from FFFFH to 0.
- R4: With mode 11 (match-clear) and register 0 in compare use, a count-enabled cycle in which the counter equals register 0 loads 0 instead of incrementing, which gives a period of register-0 value plus one.
- R5: With mode 10 (edge-clear), a rising edge on evt0In clears the counter, and the clear wins over an increment. The edge acts at the third clock edge after the input rises, because of two synchronizer stages plus edge detection.
- R6: In any running mode, a count-enabled cycle in which the counter equals a register in compare use gives one irqOut pulse on the next cycle. A match on both registers at once gives a single pulse.
- R7: toggleOut flips on a compare match in a running mode. When control bit 1 is set, it also flips on an evt0In rising edge. Coincident causes flip it exactly once.
- R8: Control bit 4 puts register 0 in capture use, loaded from the counter on an evt0In edge. Bit 5 does the same for register 1 from evt1In. The capture interrupt is raised on the next cycle that has cntEn high, not before.
- R9: Control bit 0 (overflow) is set when a count-enabled cycle takes the counter from FFFFH to 0 in modes 01 or 10, or in mode 11 when register 0 holds FFFFH.
- R10: A write of 0 to bit 0 clears the overflow flag. It is ignored from the overflow cycle until the next count-enabled cycle. Writing 1 to bit 0 has no effect.
- R11: While running, writes to control bits 5:1 are ignored, except that writing mode 00 stops the timer. While stopped, those bits take the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cntEn | input | 1 | Count-clock enable strobe |
| evt0In | input | 1 | Asynchronous event input 0 |
| evt1In | input | 1 | Asynchronous event input 1 |
| busAddr | input | 2 | Register address (0 control, 1 reg0, 2 reg1, 3 counter) |
| busWrEn | input | 1 | Register write strobe |
| busWdata | input | 16 | Register write data |
| busRdata | output | 16 | Register read data (combinational) |
| toggleOut | output | 1 | Toggle output |
| irqOut | output | 1 | One-cycle interrupt pulse |

## Verification
The bench sweeps the match-clear value from 0 to 7 while both registers hold the same value. A design that counted both coincident matches would double the interrupts or leave the toggle unchanged, and a period off by one would show in the final counter reading. The bench runs the counter through a full wrap and then tries to clear the overflow flag before the next count-enabled cycle. A design without the re-set rule would drop the flag. It also times captures against the synchronizer delay and holds cntEn low after a capture. An interrupt that fires early, or a capture of the counter after the clear, is caught there.

// File: rtl/evtTimerPkg.sv
package evtTimerPkg;
  typedef enum logic [1:0] {
    MODE_STOP  = 2'b00,
    MODE_FREE  = 2'b01,
    MODE_EDGE  = 2'b10,
    MODE_MATCH = 2'b11
  } modeE;

  // Strobes from control to datapath, one cycle each.
  typedef struct packed {
    logic cntInc;
    logic cntClr;
    logic cap0;
    logic cap1;
  } dpStrobeT;
endpackage

// File: rtl/evtTimerDatapath.sv
module evtTimerDatapath
  import evtTimerPkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  dpStrobeT     strobe,
  input  logic         wrCc0,
  input  logic         wrCc1,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] cntQ,
  output logic [W-1:0] cc0Q,
  output logic [W-1:0] cc1Q,
  output logic         eq0,
  output logic         eq1,
  output logic         atMax,
  output logic         cc0Max
);
  localparam logic [W-1:0] CNT_STEP = W'(1);
  localparam logic [W-1:0] CNT_TOP  = {W{1'b1}};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntQ <= '0;
      cc0Q <= '0;
      cc1Q <= '0;
    end else begin
      if (strobe.cntClr)      cntQ <= '0;
      else if (strobe.cntInc) cntQ <= cntQ + CNT_STEP;
      // a capture takes precedence over a software write in the same cycle
      if (strobe.cap0)        cc0Q <= cntQ;
      else if (wrCc0)         cc0Q <= wdata;
      if (strobe.cap1)        cc1Q <= cntQ;
      else if (wrCc1)         cc1Q <= wdata;
    end
  end

  assign eq0    = (cntQ == cc0Q);
  assign eq1    = (cntQ == cc1Q);
  assign atMax  = (cntQ == CNT_TOP);
  assign cc0Max = (cc0Q == CNT_TOP);
endmodule

// File: rtl/evtTimerCtrl.sv
module evtTimerCtrl
  import evtTimerPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cntEn,
  input  logic [1:0] evtIn,
  input  logic       ctrlWr,
  input  logic [5:0] wdata,
  input  logic       eq0,
  input  logic       eq1,
  input  logic       atMax,
  input  logic       cc0Max,
  output logic [7:0] ctrlQ,
  output dpStrobeT   strobe,
  output logic       toggleOut,
  output logic       irqOut
);
  localparam int NUM_EVT = 2;

  modeE       modeQ;
  logic       tglSelQ;
  logic [1:0] capModeQ;
  logic       ovfQ;
  logic       ovfArmQ;
  logic [1:0] capPendQ;
  logic [NUM_EVT-1:0] evtRise;

  // Synchronizer and rising-edge detector for each event input
  for (genvar i = 0; i < NUM_EVT; i++) begin : g_sync
    logic [SYNC_STAGES-1:0] shiftQ;
    logic                   prevQ;
    always_ff @(posedge clk) begin
      if (!rstN) begin
        shiftQ <= '0;
        prevQ  <= 1'b0;
      end else begin
        shiftQ <= {shiftQ[SYNC_STAGES-2:0], evtIn[i]};
        prevQ  <= shiftQ[SYNC_STAGES-1];
      end
    end
    assign evtRise[i] = shiftQ[SYNC_STAGES-1] & ~prevQ;
  end

  logic running, tick, match0, match1, edgeClr, matchClr, ovfHit;
  logic capIrq, irqNext, tglNext;
  logic [1:0] capHit;

  always_comb begin
    running  = (modeQ != MODE_STOP);
    tick     = running & cntEn;
    match0   = tick & eq0 & ~capModeQ[0];
    match1   = tick & eq1 & ~capModeQ[1];
    capHit   = {NUM_EVT{running}} & capModeQ & evtRise;
    edgeClr  = running & (modeQ == MODE_EDGE) & evtRise[0];
    matchClr = match0 & (modeQ == MODE_MATCH);
    ovfHit   = tick & atMax & ((modeQ != MODE_MATCH) | cc0Max);
    capIrq   = tick & (|capPendQ);
    irqNext  = match0 | match1 | capIrq;
    tglNext  = match0 | match1 | (running & tglSelQ & evtRise[0]);
    strobe.cntInc = tick;
    strobe.cntClr = ~running | edgeClr | matchClr;
    strobe.cap0   = capHit[0];
    strobe.cap1   = capHit[1];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ     <= MODE_STOP;
      tglSelQ   <= 1'b0;
      capModeQ  <= '0;
      ovfQ      <= 1'b0;
      ovfArmQ   <= 1'b0;
      capPendQ  <= '0;
      toggleOut <= 1'b0;
      irqOut    <= 1'b0;
    end else begin
      if (ctrlWr) begin
        if (!running) begin
          modeQ    <= modeE'(wdata[3:2]);
          tglSelQ  <= wdata[1];
          capModeQ <= wdata[5:4];
        end else if (wdata[3:2] == 2'b00) begin
          modeQ <= MODE_STOP;
        end
      end
      if (ovfHit)                                ovfQ <= 1'b1;
      else if (ctrlWr && !wdata[0] && !ovfArmQ)  ovfQ <= 1'b0;
      if (ovfHit)                ovfArmQ <= 1'b1;
      else if (tick || !running) ovfArmQ <= 1'b0;
      for (int i = 0; i < NUM_EVT; i++) begin
        if (!running)      capPendQ[i] <= 1'b0;
        else if (capHit[i]) capPendQ[i] <= 1'b1;
        else if (cntEn)    capPendQ[i] <= 1'b0;
      end
      irqOut    <= irqNext;
      toggleOut <= toggleOut ^ tglNext;
    end
  end

  assign ctrlQ = {2'b00, capModeQ, modeQ, tglSelQ, ovfQ};
endmodule

// File: rtl/evtTimer16.sv
module evtTimer16
  import evtTimerPkg::*;
#(
  parameter int W           = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         cntEn,
  input  logic         evt0In,
  input  logic         evt1In,
  input  logic [1:0]   busAddr,
  input  logic         busWrEn,
  input  logic [W-1:0] busWdata,
  output logic [W-1:0] busRdata,
  output logic         toggleOut,
  output logic         irqOut
);
  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_CC0  = 2'd1;
  localparam logic [1:0] ADDR_CC1  = 2'd2;

  dpStrobeT   strobe;
  logic [7:0] ctrlQ;
  logic [W-1:0] cntQ, cc0Q, cc1Q;
  logic eq0, eq1, atMax, cc0Max;

  evtTimerCtrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .cntEn(cntEn), .evtIn({evt1In, evt0In}),
    .ctrlWr(busWrEn && busAddr == ADDR_CTRL), .wdata(busWdata[5:0]),
    .eq0(eq0), .eq1(eq1), .atMax(atMax), .cc0Max(cc0Max),
    .ctrlQ(ctrlQ), .strobe(strobe), .toggleOut(toggleOut), .irqOut(irqOut)
  );

  evtTimerDatapath #(.W(W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .wrCc0(busWrEn && busAddr == ADDR_CC0),
    .wrCc1(busWrEn && busAddr == ADDR_CC1),
    .wdata(busWdata), .cntQ(cntQ), .cc0Q(cc0Q), .cc1Q(cc1Q),
    .eq0(eq0), .eq1(eq1), .atMax(atMax), .cc0Max(cc0Max)
  );

  always_comb begin
    case (busAddr)
      ADDR_CTRL: busRdata = W'(ctrlQ);
      ADDR_CC0:  busRdata = cc0Q;
      ADDR_CC1:  busRdata = cc1Q;
      default:   busRdata = cntQ;
    endcase
  end
endmodule

// File: rtl/evtTimerChecker.sv
module evtTimerChecker #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rstN,
  input logic         cntEn,
  input logic [5:0]   ctrlQ,
  input logic [W-1:0] cntQ,
  input logic [W-1:0] cc0Q,
  input logic         toggleOut,
  input logic         irqOut
);
  p_stop_cnt_r2: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlQ[3:2] == 2'b00) |=> (cntQ == '0));

  p_stop_quiet_r2: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlQ[3:2] == 2'b00) |=> (!irqOut && $stable(toggleOut)));

  p_free_inc_r3: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlQ[3:2] == 2'b01 && cntEn) |=> (cntQ == W'($past(cntQ) + 1'b1)));

  p_free_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlQ[3:2] == 2'b01 && !cntEn) |=> $stable(cntQ));

  p_match_clr_r4: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlQ[3:2] == 2'b11 && !ctrlQ[4] && cntEn && cntQ == cc0Q) |=> (cntQ == '0));

  p_ovf_wrap_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ctrlQ[0]) |-> (cntQ == '0));

  p_ovf_early_r10: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(ctrlQ[0]) && !cntEn) |=> ctrlQ[0]);

  p_ctrl_locked_r11: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlQ[3:2] != 2'b00 && $past(ctrlQ[3:2]) != 2'b00) |-> $stable(ctrlQ[5:1]));
endmodule

bind evtTimer16 evtTimerChecker #(.W(W)) u_chk (
  .clk(clk), .rstN(rstN), .cntEn(cntEn), .ctrlQ(ctrlQ[5:0]),
  .cntQ(cntQ), .cc0Q(cc0Q), .toggleOut(toggleOut), .irqOut(irqOut)
);

// File: tb/evtTimer16_bench.sv
module evtTimer16_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN, cntEn, evt0In, evt1In, busWrEn, toggleOut, irqOut;
  logic [1:0]  busAddr;
  logic [15:0] busWdata, busRdata;

  int nChecks = 0;
  int nFails  = 0;
  int irqCnt, tglCnt;
  logic lastTgl;

  always #(CLK_PERIOD/2) clk = ~clk;

  evtTimer16 u_evtTimer16 (
    .clk(clk), .rstN(rstN), .cntEn(cntEn), .evt0In(evt0In), .evt1In(evt1In),
    .busAddr(busAddr), .busWrEn(busWrEn), .busWdata(busWdata),
    .busRdata(busRdata), .toggleOut(toggleOut), .irqOut(irqOut)
  );

  task automatic chk(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Called at a negedge; returns at the negedge after the write edge.
  task automatic busWrite(input logic [1:0] a, input logic [15:0] d);
    busAddr = a; busWdata = d; busWrEn = 1'b1;
    @(posedge clk); @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic readReg(input logic [1:0] a, output int v);
    busAddr = a; #1; v = int'(busRdata);
  endtask

  task automatic step(input int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk); @(negedge clk);
      if (irqOut) irqCnt++;
      if (toggleOut != lastTgl) tglCnt++;
      lastTgl = toggleOut;
    end
  endtask

  task automatic clrCounts();
    irqCnt = 0; tglCnt = 0; lastTgl = toggleOut;
  endtask

  // Stop the timer and let the counter clear.
  task automatic stopTimer();
    cntEn = 1'b0;
    busWrite(2'd0, 16'h0000);
    step(1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    int v;
    rstN = 1'b0; cntEn = 1'b0; evt0In = 1'b0; evt1In = 1'b0;
    busAddr = '0; busWrEn = 1'b0; busWdata = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    clrCounts();

    // R1 reset state
    readReg(2'd0, v); chk("R1 ctrl", v, 0);
    readReg(2'd3, v); chk("R1 counter", v, 0);
    chk("R1 toggleOut", int'(toggleOut), 0);
    chk("R1 irqOut", int'(irqOut), 0);

    // R2 stopped: events ignored, counter held
    busWrite(2'd1, 16'd3);
    busWrite(2'd0, 16'h0030);
    cntEn = 1'b1; clrCounts();
    evt0In = 1'b1; evt1In = 1'b1; step(6);
    evt0In = 1'b0; evt1In = 1'b0; step(4);
    readReg(2'd3, v); chk("R2 counter held", v, 0);
    readReg(2'd1, v); chk("R2 reg0 no capture", v, 3);
    readReg(2'd2, v); chk("R2 reg1 no capture", v, 0);
    chk("R2 irq count", irqCnt, 0);
    chk("R2 toggle count", tglCnt, 0);

    // R3 free-running with R6/R7 compare matches
    cntEn = 1'b0;
    busWrite(2'd0, 16'h0000);
    busWrite(2'd1, 16'd5);
    busWrite(2'd2, 16'd9);
    busWrite(2'd0, 16'h0004);
    step(3);
    readReg(2'd3, v); chk("R3 hold without cntEn", v, 0);
    clrCounts(); cntEn = 1'b1; step(12); cntEn = 1'b0;
    readReg(2'd3, v); chk("R3 count 12", v, 12);
    chk("R6 irq two matches", irqCnt, 2);
    chk("R7 toggle two matches", tglCnt, 2);
    for (int i = 0; i < 10; i++) begin
      cntEn = (i % 2 == 0); step(1);
    end
    cntEn = 1'b0;
    readReg(2'd3, v); chk("R3 gated count", v, 17);

    // R11 write lock while running
    busWrite(2'd0, 16'h0036);
    readReg(2'd0, v); chk("R11 running write ignored", v, 16'h04);
    busWrite(2'd0, 16'h0005);
    readReg(2'd0, v); chk("R11 bit0 write one", v, 16'h04);
    busWrite(2'd0, 16'h0000);
    readReg(2'd0, v); chk("R11 stop accepted", v, 0);
    step(1);
    readReg(2'd3, v); chk("R2 stop clears counter", v, 0);

    // R4/R6/R7 match-clear sweep with coincident matches on both registers
    for (int p = 0; p < 8; p++) begin
      stopTimer();
      busWrite(2'd1, 16'(p));
      busWrite(2'd2, 16'(p));
      busWrite(2'd0, 16'h000C);
      clrCounts(); cntEn = 1'b1; step(24); cntEn = 1'b0;
      readReg(2'd3, v); chk("R4 counter after sweep", v, 24 % (p + 1));
      chk("R6 one irq per coincident match", irqCnt, 24 / (p + 1));
      chk("R7 one toggle per coincident match", tglCnt, 24 / (p + 1));
      readReg(2'd0, v); chk("R9 no overflow in short period", v & 1, 0);
    end

    // R5/R8/R7 edge-clear with captures and edge toggle
    stopTimer();
    busWrite(2'd1, 16'd0);
    busWrite(2'd2, 16'd0);
    busWrite(2'd0, 16'h003A);
    cntEn = 1'b1; step(10);
    readReg(2'd3, v); chk("R5 pre-edge count", v, 10);
    clrCounts();
    evt0In = 1'b1; evt1In = 1'b1;
    step(2);
    readReg(2'd3, v); chk("R5 no clear before sync delay", v, 12);
    step(1);
    readReg(2'd3, v); chk("R5 edge clears counter", v, 0);
    readReg(2'd1, v); chk("R8 reg0 captured", v, 12);
    readReg(2'd2, v); chk("R8 reg1 captured", v, 12);
    chk("R7 edge toggle", tglCnt, 1);
    chk("R8 irq not yet", irqCnt, 0);
    step(1);
    chk("R8 irq after next count", irqCnt, 1);
    evt0In = 1'b0; evt1In = 1'b0; step(3);

    // R8 capture interrupt waits for cntEn
    cntEn = 1'b0; clrCounts();
    evt1In = 1'b1; step(3);
    readReg(2'd2, v); chk("R8 frozen capture", v, 4);
    step(2);
    chk("R8 irq held without cntEn", irqCnt, 0);
    cntEn = 1'b1; step(1); cntEn = 1'b0;
    chk("R8 irq on cntEn", irqCnt, 1);
    evt1In = 1'b0;

    // R9/R10 free-running overflow and early clear
    stopTimer();
    busWrite(2'd0, 16'h0004);
    cntEn = 1'b1; step(65535);
    readReg(2'd3, v); chk("R3 reaches max", v, 16'hFFFF);
    readReg(2'd0, v); chk("R9 no flag before wrap", v & 1, 0);
    step(1); cntEn = 1'b0;
    readReg(2'd3, v); chk("R3 wraps to zero", v, 0);
    readReg(2'd0, v); chk("R9 overflow set", v & 1, 1);
    busWrite(2'd0, 16'h0004);
    readReg(2'd0, v); chk("R10 early clear ignored", v & 1, 1);
    cntEn = 1'b1; step(1); cntEn = 1'b0;
    busWrite(2'd0, 16'h0004);
    readReg(2'd0, v); chk("R10 later clear accepted", v & 1, 0);

    // R9 match-clear with register 0 at FFFFH
    stopTimer();
    busWrite(2'd1, 16'hFFFF);
    busWrite(2'd0, 16'h000C);
    cntEn = 1'b1; step(65536); cntEn = 1'b0;
    readReg(2'd3, v); chk("R4 clear at FFFFH", v, 0);
    readReg(2'd0, v); chk("R9 overflow in match mode", v & 1, 1);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule